// File: doc/BRIEF.md
# Single-Level Prioritized Interrupt Controller

This block decides when a small processor core must divert into an interrupt routine. It watches two sources. One is an active-low external pin. Several open-drain devices may pull this pin together, and it is sensed by level. The other is a pulse from an on-chip timer that marks a counter wrap, and it is held in a latch. At the last cycle of each instruction the controller may recognise a source. It then raises a call request carrying a fixed target address, 3 for the pin and 7 for the timer. The core acknowledges the request once it has pushed its return state.

After the acknowledge, the controller enters a lockout. It ignores every source until the core signals the second cycle of its return-and-restore instruction. Each source has its own enable. The pin wins over the timer. A pin level that is inverted to active-high goes out on a test port, so software can poll the pin while interrupts are off.

The controller is a three-state machine:
- IDLE: nothing is pending service. It moves to REQ ("take") at an instruction boundary when a source qualifies.
- REQ: the call request is driven with a frozen vector. It moves to SVC ("accept") on the acknowledge.
- SVC: the lockout. It moves back to IDLE ("release") on the return strobe. If the return strobe falls on a boundary and a source qualifies in that same cycle, it moves straight to REQ ("release-and-take").

Top module: `intr_ctl`

## Requirements
- R1: After reset, `call_req` is 0, both enables are off and the timer latch is empty. A low pin or a timer pulse then raises no request until an enable is set.
- R2: `ext_test` always equals the inverse of `ext_pin_n`.
- R3: The pin is sampled only on a `cyc_stb` cycle. If `two_cyc` is 1, it is sampled only in the cycle where `last_cyc` is also 1. A low pin seen only in the first cycle of a two-cycle instruction raises no request.
- R4: With the pin source enabled, a low pin on a cycle with `cyc_stb` and `last_cyc` both 1 makes `call_req` equal 1 with `call_vec` equal 3 in the next cycle.
- R5: With the timer source enabled, a `tmr_ovf` pulse is latched. The next boundary then gives `call_req` equal 1 with `call_vec` equal 7.
- R6: If both sources qualify at one boundary, the vector is 3. The timer request stays latched and is taken with vector 7 at the first boundary after the return.
- R7: After `call_ack`, no request is raised, whatever the pin, the timer or the enables do, until `rtr_cyc2`. If `rtr_cyc2` falls on a boundary with a qualifying source, the request is raised in the next cycle.
- R8: A `tmr_ovf` pulse while the timer source is disabled is not stored. Enabling the timer source later raises no request.
- R9: The timer latch clears when a vector-7 request is acknowledged and when the timer source is disabled.
- R10: While `call_ack` is 0, `call_req` stays 1 and `call_vec` stays unchanged.
- R11: If the set and clear strobes of one enable arrive in the same cycle, the enable ends up off.
- R12: With the pin source disabled, a low pin raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin_n | input | 1 | External request, active low, level sensed |
| tmr_ovf | input | 1 | One-cycle timer wrap pulse |
| ext_en_set | input | 1 | Enable the pin source |
| ext_en_clr | input | 1 | Disable the pin source |
| tmr_en_set | input | 1 | Enable the timer source |
| tmr_en_clr | input | 1 | Disable the timer source and drop its latch |
| cyc_stb | input | 1 | One pulse per instruction cycle |
| last_cyc | input | 1 | Current cycle is the last of its instruction |
| two_cyc | input | 1 | Current instruction takes two cycles |
| rtr_cyc2 | input | 1 | Second cycle of the return-and-restore instruction |
| call_ack | input | 1 | Core has taken the call |
| call_req | output | 1 | Interrupt call request |
| call_vec | output | VEC_W | Call target address (3 or 7) |
| ext_test | output | 1 | Inverted live pin level for polling |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the release of the lockout and the recognition of a new request. The bench provokes this by driving `rtr_cyc2` together with a boundary strobe while the pin is low. It judges the result by a request with vector 3 in the very next cycle. The second pair is the choice between the two sources. The bench latches a timer wrap and then presents a low pin at one boundary. It expects vector 3 first, and vector 7 only after the return.

// File: rtl/intr_pkg.sv
package intr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SVC  = 2'd2
    } intr_state_e;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_TMR = 1'b1
    } intr_src_e;

endpackage

// File: rtl/intr_ext_gate.sv
module intr_ext_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic cyc_stb,
    input  logic last_cyc,
    input  logic two_cyc,
    output logic en_q,
    output logic hit
);
    logic sample_pt;

    // clear strobe wins over set strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (en_clr)  en_q <= 1'b0;
        else if (en_set)  en_q <= 1'b1;
    end

    // two-cycle instructions sample only in their second cycle
    always_comb begin
        sample_pt = cyc_stb && (!two_cyc || last_cyc);
        hit       = sample_pt && !pin_n && en_q;
    end
endmodule

// File: rtl/intr_tmr_latch.sv
module intr_tmr_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic en_set,
    input  logic en_clr,
    input  logic take,
    output logic pend
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (en_clr)  en_q <= 1'b0;
        else if (en_set)  en_q <= 1'b1;
    end

    // disable clears; a fresh wrap outranks a vector take in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend <= 1'b0;
        else if (en_clr)            pend <= 1'b0;
        else if (ovf && en_q)       pend <= 1'b1;
        else if (take)              pend <= 1'b0;
    end
endmodule

// File: rtl/intr_lock_fsm.sv
module intr_lock_fsm
    import intr_pkg::*;
#(
    parameter int VEC_W   = 12,
    parameter int EXT_VEC = 3,
    parameter int TMR_VEC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             ext_hit,
    input  logic             tmr_pend,
    input  logic             rtr_cyc2,
    input  logic             call_ack,
    output logic             call_req,
    output logic [VEC_W-1:0] call_vec,
    output logic             tmr_take
);
    localparam logic [VEC_W-1:0] EXT_ADDR = VEC_W'(EXT_VEC);
    localparam logic [VEC_W-1:0] TMR_ADDR = VEC_W'(TMR_VEC);

    intr_state_e state_q, state_d;
    intr_src_e   src_q, src_d;
    logic        open_win;
    logic        any_src;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_EXT;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    // transitions: take, accept, release, release-and-take
    always_comb begin
        state_d  = state_q;
        src_d    = src_q;
        any_src  = ext_hit || tmr_pend;
        open_win = (state_q == ST_IDLE) || (state_q == ST_SVC && rtr_cyc2);
        unique case (state_q)
            ST_IDLE, ST_SVC: begin
                if (open_win && boundary && any_src) begin
                    state_d = ST_REQ;
                    src_d   = ext_hit ? SRC_EXT : SRC_TMR;
                end else if (open_win) begin
                    state_d = ST_IDLE;
                end
            end
            ST_REQ: begin
                if (call_ack) state_d = ST_SVC;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        call_req = (state_q == ST_REQ);
        call_vec = (src_q == SRC_TMR) ? TMR_ADDR : EXT_ADDR;
        tmr_take = call_req && call_ack && (src_q == SRC_TMR);
    end
endmodule

// File: rtl/intr_ctl.sv
module intr_ctl #(
    parameter int VEC_W   = 12,
    parameter int EXT_VEC = 3,
    parameter int TMR_VEC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin_n,
    input  logic             tmr_ovf,
    input  logic             ext_en_set,
    input  logic             ext_en_clr,
    input  logic             tmr_en_set,
    input  logic             tmr_en_clr,
    input  logic             cyc_stb,
    input  logic             last_cyc,
    input  logic             two_cyc,
    input  logic             rtr_cyc2,
    input  logic             call_ack,
    output logic             call_req,
    output logic [VEC_W-1:0] call_vec,
    output logic             ext_test
);
    logic ext_en_q;
    logic ext_hit;
    logic tmr_pend;
    logic tmr_take;
    logic boundary;

    assign boundary = cyc_stb && last_cyc;
    assign ext_test = ~ext_pin_n;

    intr_ext_gate u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (ext_pin_n),
        .en_set   (ext_en_set),
        .en_clr   (ext_en_clr),
        .cyc_stb  (cyc_stb),
        .last_cyc (last_cyc),
        .two_cyc  (two_cyc),
        .en_q     (ext_en_q),
        .hit      (ext_hit)
    );

    intr_tmr_latch u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovf    (tmr_ovf),
        .en_set (tmr_en_set),
        .en_clr (tmr_en_clr),
        .take   (tmr_take),
        .pend   (tmr_pend)
    );

    intr_lock_fsm #(
        .VEC_W   (VEC_W),
        .EXT_VEC (EXT_VEC),
        .TMR_VEC (TMR_VEC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .ext_hit  (ext_hit),
        .tmr_pend (tmr_pend),
        .rtr_cyc2 (rtr_cyc2),
        .call_ack (call_ack),
        .call_req (call_req),
        .call_vec (call_vec),
        .tmr_take (tmr_take)
    );
endmodule

// File: rtl/intr_ctl_chk.sv
module intr_ctl_chk #(
    parameter int VEC_W   = 12,
    parameter int EXT_VEC = 3,
    parameter int TMR_VEC = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_pin_n,
    input logic             ext_en_q,
    input logic             cyc_stb,
    input logic             last_cyc,
    input logic             rtr_cyc2,
    input logic             call_req,
    input logic             call_ack,
    input logic [VEC_W-1:0] call_vec
);
    logic in_svc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                   in_svc_q <= 1'b0;
        else if (call_req && call_ack) in_svc_q <= 1'b1;
        else if (rtr_cyc2)            in_svc_q <= 1'b0;
    end

    assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (call_vec == VEC_W'(EXT_VEC) || call_vec == VEC_W'(TMR_VEC)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !call_ack) |=> (call_req && $stable(call_vec)));

    assert_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> $past(cyc_stb && last_cyc));

    assert_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc_q |-> !call_req);

    assert_ext_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(call_req) && call_vec == VEC_W'(TMR_VEC)) |-> $past(!(ext_en_q && !ext_pin_n)));
endmodule

bind intr_ctl intr_ctl_chk #(
    .VEC_W   (VEC_W),
    .EXT_VEC (EXT_VEC),
    .TMR_VEC (TMR_VEC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_pin_n (ext_pin_n),
    .ext_en_q  (ext_en_q),
    .cyc_stb   (cyc_stb),
    .last_cyc  (last_cyc),
    .rtr_cyc2  (rtr_cyc2),
    .call_req  (call_req),
    .call_ack  (call_ack),
    .call_vec  (call_vec)
);

// File: tb/intr_ctl_tb.sv
module intr_ctl_tb_top;
    localparam int VEC_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_pin_n = 1'b1, tmr_ovf = 1'b0;
    logic ext_en_set = 1'b0, ext_en_clr = 1'b0, tmr_en_set = 1'b0, tmr_en_clr = 1'b0;
    logic cyc_stb = 1'b0, last_cyc = 1'b0, two_cyc = 1'b0, rtr_cyc2 = 1'b0, call_ack = 1'b0;
    logic             call_req;
    logic [VEC_W-1:0] call_vec;
    logic             ext_test;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    intr_ctl #(.VEC_W(VEC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .tmr_ovf(tmr_ovf),
        .ext_en_set(ext_en_set), .ext_en_clr(ext_en_clr),
        .tmr_en_set(tmr_en_set), .tmr_en_clr(tmr_en_clr),
        .cyc_stb(cyc_stb), .last_cyc(last_cyc), .two_cyc(two_cyc),
        .rtr_cyc2(rtr_cyc2), .call_ack(call_ack),
        .call_req(call_req), .call_vec(call_vec), .ext_test(ext_test)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic boundary1();
        cyc_stb = 1'b1; last_cyc = 1'b1; two_cyc = 1'b0;
        tick();
        cyc_stb = 1'b0; last_cyc = 1'b0;
    endtask

    task automatic pulse_ovf();
        tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
    endtask

    task automatic ack();
        call_ack = 1'b1; tick(); call_ack = 1'b0;
    endtask

    task automatic ret(input bit at_boundary);
        rtr_cyc2 = 1'b1; cyc_stb = at_boundary; last_cyc = at_boundary;
        tick();
        rtr_cyc2 = 1'b0; cyc_stb = 1'b0; last_cyc = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 req after reset", call_req, 0);
        ext_pin_n = 1'b0; boundary1();
        chk("R1 no req with pin source off", call_req, 0);
        ext_pin_n = 1'b1;
        pulse_ovf();
        tmr_en_set = 1'b1; tick(); tmr_en_set = 1'b0;
        boundary1();
        chk("R8 disabled wrap not stored", call_req, 0);
        tmr_en_clr = 1'b1; tick(); tmr_en_clr = 1'b0;
    endtask

    task automatic t_test_pin();
        ext_pin_n = 1'b0; #1;
        chk("R2 test port low pin", ext_test, 1);
        ext_pin_n = 1'b1; #1;
        chk("R2 test port high pin", ext_test, 0);
    endtask

    task automatic t_ext_path();
        ext_en_set = 1'b1; tick(); ext_en_set = 1'b0;
        // two-cycle instruction, pin low only in first cycle
        ext_pin_n = 1'b0; cyc_stb = 1'b1; two_cyc = 1'b1; last_cyc = 1'b0;
        tick();
        chk("R3 first cycle not sampled", call_req, 0);
        ext_pin_n = 1'b1; last_cyc = 1'b1;
        tick();
        cyc_stb = 1'b0; last_cyc = 1'b0; two_cyc = 1'b0;
        chk("R3 high at second cycle", call_req, 0);
        ext_pin_n = 1'b0; tick();
        chk("R3 no strobe no sample", call_req, 0);
        boundary1();
        chk("R4 pin request raised", call_req, 1);
        chk("R4 pin vector", call_vec, 3);
        ext_pin_n = 1'b1; tick(); tick();
        chk("R10 req held", call_req, 1);
        chk("R10 vector held", call_vec, 3);
        ack();
        chk("R7 req drops on ack", call_req, 0);
        ext_pin_n = 1'b0; boundary1(); boundary1();
        chk("R7 pin locked out", call_req, 0);
        tmr_en_set = 1'b1; tick(); tmr_en_set = 1'b0;
        pulse_ovf(); boundary1();
        chk("R7 timer locked out", call_req, 0);
        ret(1'b1);
        chk("R7 release-and-take req", call_req, 1);
        chk("R7 release-and-take vec", call_vec, 3);
        ack();
        ext_pin_n = 1'b1;
        ret(1'b0);
        chk("R6 nothing until boundary", call_req, 0);
        boundary1();
        chk("R5 timer request", call_req, 1);
        chk("R5 timer vector", call_vec, 7);
        ack(); ret(1'b0); boundary1();
        chk("R9 latch cleared by take", call_req, 0);
    endtask

    task automatic t_priority();
        pulse_ovf();
        ext_pin_n = 1'b0; boundary1();
        chk("R6 pin wins vector", call_vec, 3);
        chk("R6 pin wins req", call_req, 1);
        ack(); ext_pin_n = 1'b1; ret(1'b0); boundary1();
        chk("R6 timer kept req", call_req, 1);
        chk("R6 timer kept vec", call_vec, 7);
        ack(); ret(1'b0);
    endtask

    task automatic t_tmr_disable();
        pulse_ovf();
        tmr_en_clr = 1'b1; tick(); tmr_en_clr = 1'b0;
        tmr_en_set = 1'b1; tick(); tmr_en_set = 1'b0;
        boundary1();
        chk("R9 latch cleared by disable", call_req, 0);
    endtask

    task automatic t_enables();
        tmr_en_clr = 1'b1; tmr_en_set = 1'b1; tick();
        tmr_en_clr = 1'b0; tmr_en_set = 1'b0;
        pulse_ovf(); boundary1();
        chk("R11 timer clear wins", call_req, 0);
        ext_en_clr = 1'b1; ext_en_set = 1'b1; tick();
        ext_en_clr = 1'b0; ext_en_set = 1'b0;
        ext_pin_n = 1'b0; boundary1();
        chk("R11 pin clear wins", call_req, 0);
        chk("R12 disabled pin ignored", call_req, 0);
        ext_pin_n = 1'b1;
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        join_none
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_test_pin();
        t_ext_path();
        t_priority();
        t_tmr_disable();
        t_enables();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule